// File: doc/BRIEF.md
# SPI Register Slave with Strap-Selected Device Address

This block lets a host reach a small bank of 8-bit control registers over a four-wire serial link that idles with the clock low and samples on its rising edge. The chip-select, serial clock and serial data inputs are brought into the system clock domain through two-flop synchronizers. Frame decoding, register writes and read-back all run on the system clock, so the rest of the chip sees plain synchronous register outputs.

Several such devices may share one link. Each one learns its 3-bit device address from three pins, which are sampled for as long as reset is held. Once reset is released, the same three pins are driven as general-purpose outputs from the low bits of register 0. A frame whose address field does not match the captured value is dropped. A write takes effect only when chip select is released after exactly sixteen clocks. A one-cycle strobe tells downstream logic that a valid frame has ended.

A frame has sixteen bits and is sent most significant bit first:

| Bits | Field |
|------|-------|
| 15:13 | device address |
| 12 | direction: 0 = write, 1 = read |
| 11:8 | register index |
| 7:0 | data |

Top module: `spi_reg_slave`

## Requirements
- R1: While `rst` is high, and on the first clock after it is released, every register reads 0. In that state `gp_oe_o`, `gp_out_o`, `sdo_oe_o` and `frame_done_o` are all 0.
- R2: The device address is the value on `gp_strap_i` in the last clock cycle of reset. Any later change on `gp_strap_i` has no effect until the next reset.
- R3: Data on `mosi_i` is sampled on the rising edge of `sclk_i`. The sixteen bits of a frame are taken most significant bit first, with the field layout shown in the table above. Each phase of `sclk_i`, high and low, lasts at least 4 system clock periods.
- R4: A write is committed only after `cs_n_i` rises. Four conditions must all hold: exactly 16 rising clock edges were received, the address matches, the direction bit is 0, and the index is below NUM_REGS (12). The data then appears on `regs_o[8*index +: 8]`. Writes to indexes 12 to 15 change nothing.
- R5: A frame with a rising-edge count other than 16 changes no register and produces no `frame_done_o` pulse.
- R6: A frame whose address field does not match the strapped address changes no register. During such a frame `sdo_oe_o` stays 0 and no `frame_done_o` pulse is produced.
- R7: In a matched read frame, `sdo_oe_o` goes high after the eighth rising clock edge. The indexed register is then shifted out on `sdo_o` most significant bit first, with each new bit presented on a falling edge of `sclk_i`. A read of index 12 to 15 returns 0.
- R8: `sdo_oe_o` is 0 whenever `cs_n_i` is high.
- R9: Edges on `sclk_i` while `cs_n_i` is high are ignored. They change no register, produce no strobe, and do not disturb the next frame.
- R10: After reset, `gp_oe_o` is 1 and `gp_out_o` equals bits 2:0 of register 0.
- R11: `frame_done_o` pulses high for exactly one clock after the end of each matched frame with exactly 16 clock edges, whether it was a read or a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; strap pins are sampled while it is high |
| cs_n_i | input | 1 | Chip select, active low; frames the transfer |
| sclk_i | input | 1 | Serial clock from the host, idles low |
| mosi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` (the pad is high-impedance when 0) |
| gp_strap_i | input | 3 | Address strap input from the shared pins |
| gp_out_o | output | 3 | Value driven onto the shared pins after reset |
| gp_oe_o | output | 1 | Output enable for the shared pins |
| regs_o | output | 96 | All registers, register i in bits 8*i+7 to 8*i |
| frame_done_o | output | 1 | One-cycle strobe at the end of a valid matched frame |

## Verification
Random frames are drawn with a matching or non-matching address, either direction, an index across the full 4-bit range, random data, and an occasional 15 or 17 clock count. This mix separates three cases: the address gate, the clock-count gate, and the index limit. Directed frames test the following:
- the last valid index and the first invalid one;
- register 0 driving the shared pins;
- clock toggling while deselected;
- strap pins that change after reset;
- a second reset with a new address.

Reads are compared bit by bit, sampled just before each rising edge, which separates wrong bit order from a wrong edge timing.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  parameter int ADDR_W = 3;
  parameter int IDX_W  = 4;
  parameter int DATA_W = 8;

  typedef struct packed {
    logic [ADDR_W-1:0] dev;
    logic              rd;
    logic [IDX_W-1:0]  idx;
  } frame_hdr_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_reg_pkg::*;
#(
  parameter int A_W = ADDR_W,
  parameter int I_W = IDX_W,
  parameter int D_W = DATA_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_n_s,
  input  logic           sclk_s,
  input  logic           mosi_s,
  input  logic [A_W-1:0] dev_addr_i,
  input  logic [D_W-1:0] rd_data_i,
  output logic [I_W-1:0] rd_idx_o,
  output logic           wr_en_o,
  output logic [I_W-1:0] wr_idx_o,
  output logic [D_W-1:0] wr_data_o,
  output logic           sdo_o,
  output logic           oe_o,
  output logic           done_o,
  output logic           sclk_fall_o,
  output logic           cs_fall_o
);
  localparam int HDR_W   = A_W + 1 + I_W;
  localparam int FRAME_W = HDR_W + D_W;
  localparam int SR_W    = (HDR_W > D_W) ? HDR_W : D_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic             cs_d_q, sclk_d_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SR_W-1:0]  sr_q;
  logic [HDR_W-1:0] hdr_q;
  logic             hdr_ok_q;
  logic             load1_q, load2_q;
  logic [D_W-1:0]   tx_q;
  logic             sdo_q, oe_q, done_q, wr_en_q;
  logic [I_W-1:0]   wr_idx_q;
  logic [D_W-1:0]   wr_data_q;

  logic             active, sclk_rise, sclk_fall, cs_fall, cs_rise;
  logic [A_W-1:0]   hdr_dev;
  logic             hdr_rd;
  logic [I_W-1:0]   hdr_idx;
  logic             hdr_hit;

  assign active    = ~cs_n_s;
  assign sclk_rise = active & sclk_s & ~sclk_d_q;
  assign sclk_fall = active & ~sclk_s & sclk_d_q;
  assign cs_fall   = cs_d_q & ~cs_n_s;
  assign cs_rise   = ~cs_d_q & cs_n_s;

  assign hdr_dev = hdr_q[HDR_W-1 -: A_W];
  assign hdr_rd  = hdr_q[I_W];
  assign hdr_idx = hdr_q[I_W-1:0];
  assign hdr_hit = hdr_ok_q && (hdr_dev == dev_addr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d_q    <= 1'b1;
      sclk_d_q  <= 1'b0;
      cnt_q     <= '0;
      sr_q      <= '0;
      hdr_q     <= '0;
      hdr_ok_q  <= 1'b0;
      load1_q   <= 1'b0;
      load2_q   <= 1'b0;
      tx_q      <= '0;
      sdo_q     <= 1'b0;
      oe_q      <= 1'b0;
      done_q    <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else begin
      cs_d_q   <= cs_n_s;
      sclk_d_q <= sclk_s;
      done_q   <= 1'b0;
      wr_en_q  <= 1'b0;
      load1_q  <= 1'b0;
      load2_q  <= load1_q;
      if (cs_fall) begin
        cnt_q    <= '0;
        sr_q     <= '0;
        hdr_ok_q <= 1'b0;
        tx_q     <= '0;
        sdo_q    <= 1'b0;
        oe_q     <= 1'b0;
        load2_q  <= 1'b0;
      end else if (cs_rise) begin
        oe_q <= 1'b0;
        if (cnt_q == CNT_FULL && hdr_hit) begin
          done_q    <= 1'b1;
          wr_en_q   <= ~hdr_rd;
          wr_idx_q  <= hdr_idx;
          wr_data_q <= sr_q[D_W-1:0];
        end
      end else begin
        if (sclk_rise) begin
          sr_q <= {sr_q[SR_W-2:0], mosi_s};
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
        if (!hdr_ok_q && cnt_q == CNT_HDR) begin
          hdr_q    <= sr_q[HDR_W-1:0];
          hdr_ok_q <= 1'b1;
          load1_q  <= 1'b1;
        end
        if (load2_q) begin
          tx_q <= rd_data_i;
          oe_q <= hdr_hit & hdr_rd;
        end else if (sclk_fall && hdr_ok_q && cnt_q < CNT_FULL) begin
          sdo_q <= tx_q[D_W-1];
          tx_q  <= {tx_q[D_W-2:0], 1'b0};
        end
      end
    end
  end

  assign rd_idx_o    = hdr_idx;
  assign wr_en_o     = wr_en_q;
  assign wr_idx_o    = wr_idx_q;
  assign wr_data_o   = wr_data_q;
  assign sdo_o       = sdo_q;
  assign oe_o        = oe_q;
  assign done_o      = done_q;
  assign sclk_fall_o = sclk_fall;
  assign cs_fall_o   = cs_fall;
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile #(
  parameter int NREG   = 12,
  parameter int D_W    = 8,
  parameter int I_W    = 4,
  parameter int GP_W   = 3,
  parameter int GP_IDX = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [I_W-1:0]    wr_idx_i,
  input  logic [D_W-1:0]    wr_data_i,
  input  logic [I_W-1:0]    rd_idx_i,
  output logic [D_W-1:0]    rd_data_o,
  output logic [NREG*D_W-1:0] regs_o,
  output logic [GP_W-1:0]   gp_o
);
  localparam logic [I_W:0] LIMIT = (I_W+1)'(NREG);

  logic [NREG-1:0][D_W-1:0] mem_q;
  logic [D_W-1:0]           rd_q;
  logic [GP_W-1:0]          gp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_q <= '0;
    end else if (wr_en_i && ({1'b0, wr_idx_i} < LIMIT)) begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_idx_i == I_W'(i)) mem_q[i] <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
      gp_q <= '0;
    end else begin
      rd_q <= '0;
      for (int i = 0; i < NREG; i++) begin
        if (rd_idx_i == I_W'(i)) rd_q <= mem_q[i];
      end
      gp_q <= mem_q[GP_IDX][GP_W-1:0];
    end
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_flat
      assign regs_o[g*D_W +: D_W] = mem_q[g];
    end
  endgenerate

  assign rd_data_o = rd_q;
  assign gp_o      = gp_q;
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int NUM_REGS = 12,
  parameter int GP_REG   = 0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cs_n_i,
  input  logic                       sclk_i,
  input  logic                       mosi_i,
  output logic                       sdo_o,
  output logic                       sdo_oe_o,
  input  logic [ADDR_W-1:0]          gp_strap_i,
  output logic [ADDR_W-1:0]          gp_out_o,
  output logic                       gp_oe_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic                       frame_done_o
);
  logic [2:0]        pins_s;
  logic [ADDR_W-1:0] strap_q;
  logic              gp_oe_q;
  logic [DATA_W-1:0] rd_data;
  logic [IDX_W-1:0]  rd_idx;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic              oe_q;
  logic              sclk_fall;
  logic              cs_fall;

  spi_in_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({cs_n_i, sclk_i, mosi_i}),
    .q_o (pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      strap_q <= gp_strap_i;
      gp_oe_q <= 1'b0;
    end else begin
      gp_oe_q <= 1'b1;
    end
  end

  spi_frame_engine #(.A_W(ADDR_W), .I_W(IDX_W), .D_W(DATA_W)) u_eng (
    .clk         (clk),
    .rst         (rst),
    .cs_n_s      (pins_s[2]),
    .sclk_s      (pins_s[1]),
    .mosi_s      (pins_s[0]),
    .dev_addr_i  (strap_q),
    .rd_data_i   (rd_data),
    .rd_idx_o    (rd_idx),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .wr_data_o   (wr_data),
    .sdo_o       (sdo_o),
    .oe_o        (oe_q),
    .done_o      (frame_done_o),
    .sclk_fall_o (sclk_fall),
    .cs_fall_o   (cs_fall)
  );

  spi_regfile #(
    .NREG(NUM_REGS), .D_W(DATA_W), .I_W(IDX_W), .GP_W(ADDR_W), .GP_IDX(GP_REG)
  ) u_rf (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .regs_o    (regs_o),
    .gp_o      (gp_out_o)
  );

  // Raw pin gating keeps the driver off the instant select is released.
  assign sdo_oe_o = oe_q & ~cs_n_i;
  assign gp_oe_o  = gp_oe_q;
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter int REGS_W = 96,
  parameter int A_W    = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              sdo_o,
  input logic [REGS_W-1:0] regs_o,
  input logic              frame_done_o,
  input logic              gp_oe_o,
  input logic [A_W-1:0]    strap_q,
  input logic              sclk_fall,
  input logic              cs_fall
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) frame_done_o |=> !frame_done_o); // R11
  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst) !frame_done_o |=> $stable(regs_o)); // R4
  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> $stable(strap_q)); // R2
  AST_SDO_EDGE: assert property (@(posedge clk) disable iff (rst) (!sclk_fall && !cs_fall) |=> $stable(sdo_o)); // R7
  AST_GP_DRIVE: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> gp_oe_o); // R10
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.REGS_W(NUM_REGS*spi_reg_pkg::DATA_W), .A_W(spi_reg_pkg::ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sdo_o        (sdo_o),
  .regs_o       (regs_o),
  .frame_done_o (frame_done_o),
  .gp_oe_o      (gp_oe_o),
  .strap_q      (strap_q),
  .sclk_fall    (sclk_fall),
  .cs_fall      (cs_fall)
);

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb;
  localparam int NREG = 12;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sdo_o, sdo_oe_o, gp_oe_o, frame_done_o;
  logic [2:0] gp_out_o;
  logic [NREG*8-1:0] regs_o;

  int checks = 0, errors = 0;
  int done_cnt = 0;
  bit oe_any, oe_early;
  logic [2:0] dev;
  logic [7:0] model [NREG];

  always #2 clk = ~clk;

  spi_reg_slave #(.NUM_REGS(NREG), .GP_REG(0)) u_dut (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .mosi_i(mosi),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .gp_strap_i(strap), .gp_out_o(gp_out_o),
    .gp_oe_o(gp_oe_o), .regs_o(regs_o), .frame_done_o(frame_done_o)
  );

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (frame_done_o) done_cnt++;
      if (sdo_oe_o) oe_any = 1'b1;
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit model_match(input logic [NREG*8-1:0] r);
    for (int i = 0; i < NREG; i++) if (r[i*8 +: 8] !== model[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [7:0] exp_read(input logic [3:0] idx);
    return (idx < NREG) ? model[idx] : 8'h00;
  endfunction

  task automatic xfer(input logic [2:0] a, input logic rw, input logic [3:0] idx,
                      input logic [7:0] d, input int nbits, output logic [7:0] rdv);
    logic [15:0] w;
    w = {a, rw, idx, d};
    rdv = 8'h00;
    oe_any = 1'b0;
    oe_early = 1'b0;
    cs_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'($urandom % 2);
      tick(HALF);
      if (i >= 8 && i < 16) rdv[15-i] = sdo_o;
      if (i < 8 && oe_any) oe_early = 1'b1;
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
    tick(HALF);
    cs_n = 1'b1;
  endtask

  // Runs one frame and checks every observable against the model.
  task automatic frame(input logic [2:0] a, input logic rw, input logic [3:0] idx,
                       input logic [7:0] d, input int nbits);
    logic [7:0] rdv, er;
    int d0;
    bit hit, full;
    hit  = (a == dev);
    full = (nbits == 16);
    er   = exp_read(idx);
    d0   = done_cnt;
    xfer(a, rw, idx, d, nbits, rdv);
    #1;
    chk(sdo_oe_o == 1'b0, "R8 oe low after select release", int'(sdo_oe_o), 0);
    tick(12);
    if (hit && full && !rw && idx < NREG) model[idx] = d;
    chk(model_match(regs_o), (hit ? (full ? "R4 register file" : "R5 short/long frame")
                                   : "R6 address mismatch"), int'(regs_o[31:0]), int'({model[3], model[2], model[1], model[0]}));
    chk((done_cnt - d0) == ((hit && full) ? 1 : 0), "R11 done strobe count", done_cnt - d0, (hit && full) ? 1 : 0);
    chk(oe_any == (hit && rw && nbits > 8) && !oe_early, hit ? "R7 output enable window" : "R6 oe stays low",
        int'(oe_any), int'(hit && rw && nbits > 8));
    if (hit && rw && nbits >= 16)
      chk(rdv == er, "R7 read data", int'(rdv), int'(er));
  endtask

  task automatic do_reset(input logic [2:0] s);
    strap = s;
    rst = 1'b1;
    tick(4);
    chk(regs_o == '0 && gp_oe_o == 1'b0 && gp_out_o == 3'b0 && sdo_oe_o == 1'b0 && frame_done_o == 1'b0,
        "R1 reset state", int'(regs_o[31:0]), 0);
    rst = 1'b0;
    tick(1);
    chk(regs_o == '0 && gp_out_o == 3'b0, "R1 first cycle after reset", int'(regs_o[31:0]), 0);
    dev = s;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    strap = ~s;  // R2: pins now change freely
    tick(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] rdv;
    int d0;
    void'($urandom(32'd20240611));
    do_reset(3'b101);
    chk(gp_oe_o == 1'b1, "R10 gp output enabled", int'(gp_oe_o), 1);

    // R3 R4 directed write, then R10 pins follow register 0
    frame(dev, 1'b0, 4'd0, 8'hA6, 16);
    chk(gp_out_o == 3'b110, "R10 gp_out from reg0", int'(gp_out_o), 6);
    frame(dev, 1'b0, 4'd11, 8'h5C, 16);       // R4 last valid index
    frame(dev, 1'b0, 4'd12, 8'hFF, 16);       // R4 first invalid index
    frame(dev, 1'b1, 4'd11, 8'h00, 16);       // R7 read back
    frame(dev, 1'b1, 4'd13, 8'h00, 16);       // R7 out-of-range read gives 0
    frame(dev, 1'b0, 4'd3, 8'h77, 15);        // R5 short
    frame(dev, 1'b0, 4'd3, 8'h77, 17);        // R5 long
    frame(~dev, 1'b0, 4'd3, 8'h77, 16);       // R6 wrong address write
    frame(~dev, 1'b1, 4'd11, 8'h00, 16);      // R6 wrong address read

    // R9 clock toggles while deselected
    d0 = done_cnt;
    for (int i = 0; i < 20; i++) begin
      mosi = 1'($urandom % 2);
      sclk = 1'b1; tick(HALF);
      sclk = 1'b0; tick(HALF);
    end
    chk(model_match(regs_o) && done_cnt == d0, "R9 deselected clocks ignored", done_cnt - d0, 0);
    frame(dev, 1'b0, 4'd5, 8'h3D, 16);
    frame(dev, 1'b1, 4'd5, 8'h00, 16);        // R9 next frame intact

    // R3 random mix
    for (int n = 0; n < 120; n++) begin
      logic [2:0] a;
      int nb;
      a = ($urandom % 2) ? dev : 3'($urandom);
      nb = (($urandom % 8) == 0) ? (($urandom % 2) ? 15 : 17) : 16;
      frame(a, 1'($urandom), 4'($urandom), 8'($urandom), nb);
    end
    chk(gp_out_o == model[0][2:0], "R10 gp_out tracks reg0", int'(gp_out_o), int'(model[0][2:0]));

    // R2 second reset picks up a new address
    do_reset(3'b011);
    frame(3'b101, 1'b0, 4'd2, 8'h11, 16);
    frame(3'b011, 1'b0, 4'd2, 8'h22, 16);
    frame(3'b011, 1'b1, 4'd2, 8'h00, 16);
    xfer(3'b011, 1'b1, 4'd2, 8'h00, 16, rdv);
    tick(12);
    chk(rdv == 8'h22, "R2 new strap address active", int'(rdv), 8'h22);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule